// File: doc/BRIEF.md
# Serial-Loaded Twelve-Channel Code Register Bank

This block holds twelve 8-bit converter codes and loads them one at a time over a three-wire serial link: a serial clock, a data line and an active-low select. While select is low, each rising edge of the serial clock shifts one data bit into a capture register, most significant bit first. A frame is twelve bits: a 4-bit channel address followed by the 8-bit code. When select goes high again, the block checks the frame. If it has exactly twelve bits and a valid address, the code is written into that one channel register. Otherwise the frame is dropped.

All serial inputs are sampled by a free-running system clock, which must run at least twice as fast as the serial clock. Edges of the serial clock and of the select line are found from one registered copy of each. A separate preset input acts asynchronously and forces every channel to midscale (0x80). It stays in force for as long as it is held high. A shutdown input only drives a status flag and never changes a stored code. Each successful write is reported by a one-cycle strobe that carries the index of the written channel. All twelve codes are available side by side on one flat output bus.

Top module: `serdac_regbank`

## Requirements
- R1: While `rst_n` is low, and right after it is released, every channel code reads 0x80, `wr_stb_o` is 0 and `sleep_o` is 0.
- R2: A bit on `ser_din_i` is captured on each rising edge of `ser_clk_i` only while `ser_csn_i` is low. The first captured bit is the most significant bit. Bits 11..8 of a frame are the address and bits 7..0 are the code. Serial clock edges while select is high have no effect.
- R3: On the system clock edge that first samples `ser_csn_i` high after it was low, a frame of exactly 12 bits with address k (0 to 11) writes its code into channel k. Channel k appears on `codes_o[8k+7:8k]`, and all other channels are unchanged.
- R4: A frame with any bit count other than 12 (for example 11 or 13) writes no channel and produces no strobe.
- R5: Addresses 12 to 15 write no channel and produce no strobe.
- R6: While `preset_i` is high, every channel reads 0x80, without waiting for a clock edge. A commit that coincides with preset writes nothing and produces no strobe.
- R7: `sleep_o` follows `shdn_i` one system clock later. Shutdown leaves every stored code unchanged, and serial loads are still accepted while it is high.
- R8: Each register write raises `wr_stb_o` for exactly one cycle, in the cycle after the commit edge. During that cycle `wr_chan_o` holds the index of the written channel.
- R9: Channel codes change only through a strobed write, the preset or the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_clk_i | input | 1 | Serial bit clock; data is taken on its rising edge |
| ser_csn_i | input | 1 | Active-low frame select; its rising edge commits the frame |
| ser_din_i | input | 1 | Serial data, most significant bit first |
| preset_i | input | 1 | Asynchronous preset of all channels to midscale, active high |
| shdn_i | input | 1 | Shutdown request, reported only as a status flag |
| codes_o | output | 96 | Twelve 8-bit channel codes, channel k at bits 8k+7..8k |
| wr_stb_o | output | 1 | One-cycle pulse after each channel write |
| wr_chan_o | output | 4 | Index of the channel written, valid with the strobe |
| sleep_o | output | 1 | Registered shutdown status |

## Verification
The hardest case to reach is a commit that lands while the preset is held. The frame must arrive complete, with a valid address and exactly twelve bits, so that only the preset can block it. The stimulus holds the preset high through the whole frame. It then checks that no strobe appears and that all codes stay at midscale. After the preset is released, the next frame must load normally. A second subtle case is serial clock activity while select is high, which must not leave a stale bit count. Three clock pulses are sent with select high, and a legal frame follows at once and must still land.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
  localparam int unsigned NCH_DEF    = 12;
  localparam int unsigned ADDR_W_DEF = 4;
  localparam int unsigned DATA_W_DEF = 8;
  localparam logic [7:0]  MID_DEF    = 8'h80;
endpackage

// File: rtl/serdac_rst_sync.sv
module serdac_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sn
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sn = sync_q;
endmodule

// File: rtl/serdac_serial_rx.sv
module serdac_serial_rx #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_csn_i,
  input  logic              ser_din_i,
  output logic              commit_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned FRAME_W = ADDR_W + DATA_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic               sclk_q;
  logic               csn_q;
  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               shift_en;
  logic               cs_rise;

  always_comb begin
    shift_en = ser_clk_i & ~sclk_q & ~ser_csn_i;
    cs_rise  = ser_csn_i & ~csn_q;
    sr_d     = {sr_q[FRAME_W-2:0], ser_din_i};
    cnt_d    = cnt_q;
    if (ser_csn_i) begin
      cnt_d = '0;
    end else if (shift_en && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      csn_q  <= 1'b1;
      sr_q   <= '0;
      cnt_q  <= '0;
    end else begin
      sclk_q <= ser_clk_i;
      csn_q  <= ser_csn_i;
      cnt_q  <= cnt_d;
      if (shift_en) begin
        sr_q <= sr_d;
      end
    end
  end

  assign commit_o = cs_rise & (cnt_q == CNT_FULL);
  assign addr_o   = sr_q[FRAME_W-1:DATA_W];
  assign data_o   = sr_q[DATA_W-1:0];
endmodule

// File: rtl/serdac_chan_bank.sv
module serdac_chan_bank #(
  parameter int unsigned NCH      = 12,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter logic [DATA_W-1:0] MIDSCALE = 8'h80
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  preset_i,
  input  logic                  commit_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     data_i,
  output logic [NCH*DATA_W-1:0] codes_o,
  output logic                  wr_stb_o,
  output logic [ADDR_W-1:0]     wr_chan_o
);
  localparam logic [ADDR_W:0] NCH_X = (ADDR_W+1)'(NCH);

  logic [NCH-1:0]    wen;
  logic              addr_ok;
  logic              stb_d;
  logic              stb_q;
  logic [ADDR_W-1:0] chan_q;

  always_comb begin
    addr_ok = ({1'b0, addr_i} < NCH_X);
    stb_d   = commit_i & addr_ok & ~preset_i;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic [DATA_W-1:0] code_q;

    assign wen[g] = commit_i & (addr_i == ADDR_W'(g));

    always_ff @(posedge clk or negedge rst_n or posedge preset_i) begin
      if (!rst_n) begin
        code_q <= MIDSCALE;
      end else if (preset_i) begin
        code_q <= MIDSCALE;
      end else if (wen[g]) begin
        code_q <= data_i;
      end
    end

    assign codes_o[g*DATA_W +: DATA_W] = code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q  <= 1'b0;
      chan_q <= '0;
    end else begin
      stb_q <= stb_d;
      if (stb_d) begin
        chan_q <= addr_i;
      end
    end
  end

  assign wr_stb_o  = stb_q;
  assign wr_chan_o = chan_q;
endmodule

// File: rtl/serdac_regbank.sv
module serdac_regbank
  import serdac_pkg::*;
#(
  parameter int unsigned NCH    = NCH_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter logic [DATA_W-1:0] MIDSCALE = MID_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ser_clk_i,
  input  logic                  ser_csn_i,
  input  logic                  ser_din_i,
  input  logic                  preset_i,
  input  logic                  shdn_i,
  output logic [NCH*DATA_W-1:0] codes_o,
  output logic                  wr_stb_o,
  output logic [ADDR_W-1:0]     wr_chan_o,
  output logic                  sleep_o
);
  logic              rst_sn;
  logic              commit;
  logic [ADDR_W-1:0] frm_addr;
  logic [DATA_W-1:0] frm_data;
  logic              sleep_q;

  serdac_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_sn (rst_sn)
  );

  serdac_serial_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_sn),
    .ser_clk_i (ser_clk_i),
    .ser_csn_i (ser_csn_i),
    .ser_din_i (ser_din_i),
    .commit_o  (commit),
    .addr_o    (frm_addr),
    .data_o    (frm_data)
  );

  serdac_chan_bank #(
    .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIDSCALE(MIDSCALE)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_sn),
    .preset_i  (preset_i),
    .commit_i  (commit),
    .addr_i    (frm_addr),
    .data_i    (frm_data),
    .codes_o   (codes_o),
    .wr_stb_o  (wr_stb_o),
    .wr_chan_o (wr_chan_o)
  );

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sleep_q <= 1'b0;
    end else begin
      sleep_q <= shdn_i;
    end
  end

  assign sleep_o = sleep_q;
endmodule

// File: rtl/serdac_regbank_chk.sv
module serdac_regbank_chk #(
  parameter int unsigned NCH    = 12,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] MIDSCALE = 8'h80
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ser_csn_i,
  input logic                  preset_i,
  input logic [NCH*DATA_W-1:0] codes_o,
  input logic                  wr_stb_o,
  input logic [ADDR_W-1:0]     wr_chan_o
);
  localparam logic [ADDR_W:0] NCH_X = (ADDR_W+1)'(NCH);

  AST_STB_AFTER_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> ($past(ser_csn_i) && !$past(ser_csn_i, 2))); // R3

  AST_STB_CHAN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> ({1'b0, wr_chan_o} < NCH_X)); // R5

  AST_PRESET_MIDSCALE: assert property (@(posedge clk) disable iff (!rst_n)
    preset_i |-> (codes_o == {NCH{MIDSCALE}})); // R6

  AST_STB_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o); // R8

  AST_CODES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb_o && !preset_i && !$past(preset_i)) |-> $stable(codes_o)); // R9
endmodule

bind serdac_regbank serdac_regbank_chk #(
  .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIDSCALE(MIDSCALE)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ser_csn_i (ser_csn_i),
  .preset_i  (preset_i),
  .codes_o   (codes_o),
  .wr_stb_o  (wr_stb_o),
  .wr_chan_o (wr_chan_o)
);

// File: tb/serdac_regbank_tb_top.sv
`timescale 1ns/1ps
module serdac_regbank_tb_top;
  localparam int NCH = 12;
  localparam int NV  = 8;
  // vector fields: bit count [16:12], address [11:8], code [7:0]
  localparam logic [16:0] VEC [NV] = '{
    {5'd12, 4'd0,  8'h11},
    {5'd12, 4'd11, 8'hA5},
    {5'd12, 4'd5,  8'h3C},
    {5'd11, 4'd2,  8'h77},
    {5'd13, 4'd3,  8'h44},
    {5'd12, 4'd12, 8'hEE},
    {5'd12, 4'd15, 8'h01},
    {5'd12, 4'd0,  8'hFF}
  };

  logic clk = 1'b0;
  logic rst_n, ser_clk, ser_csn, ser_din, preset, shdn;
  logic [NCH*8-1:0] codes;
  logic wr_stb, sleep;
  logic [3:0] wr_chan;

  logic [7:0] mdl [NCH];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [4:0] nb;
  logic [3:0] ad;
  logic [7:0] dt;
  logic exp_stb;

  always #2 clk = ~clk;

  serdac_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_csn_i(ser_csn),
    .ser_din_i(ser_din), .preset_i(preset), .shdn_i(shdn),
    .codes_o(codes), .wr_stb_o(wr_stb), .wr_chan_o(wr_chan), .sleep_o(sleep)
  );

  function automatic logic [NCH*8-1:0] pack_mdl();
    logic [NCH*8-1:0] v;
    for (int k = 0; k < NCH; k++) v[k*8 +: 8] = mdl[k];
    return v;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mdl_mid();
    for (int k = 0; k < NCH; k++) mdl[k] = 8'h80;
  endtask

  // sends nbits bits of {a,d}, MSB first (padding zeros past 12), then raises select;
  // returns at the falling clock edge right after the commit edge
  task automatic send_frame(input int nbits, input logic [3:0] a, input logic [7:0] d);
    logic [11:0] w;
    w = {a, d};
    @(negedge clk) ser_csn = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk) begin ser_din = (i < 12) ? w[11-i] : 1'b0; ser_clk = 1'b0; end
      @(negedge clk) ser_clk = 1'b1;
      @(negedge clk) ser_clk = 1'b0;
    end
    @(negedge clk) ser_csn = 1'b1;
    @(negedge clk);
  endtask

  // checks the strobe cycle and the following cycle
  task automatic check_commit(input string req, input logic stb, input logic [3:0] ch);
    check({req, " codes"}, codes, pack_mdl());
    check({req, " strobe"}, wr_stb, stb);
    if (stb) check({req, " chan"}, wr_chan, ch);
    @(negedge clk);
    check("R8 strobe drops", wr_stb, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ser_clk = 1'b0; ser_csn = 1'b1; ser_din = 1'b0;
    preset = 1'b0; shdn = 1'b0;
    mdl_mid();
    repeat (3) @(negedge clk);
    check("R1 codes in reset", codes, pack_mdl());
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 codes after reset", codes, pack_mdl());
    check("R1 strobe after reset", wr_stb, 1'b0);
    check("R1 sleep after reset", sleep, 1'b0);

    // table walk: R2 R3 R4 R5 R8 R9
    for (int v = 0; v < NV; v++) begin
      nb = VEC[v][16:12];
      ad = VEC[v][11:8];
      dt = VEC[v][7:0];
      exp_stb = (nb == 5'd12) && (ad < 4'd12);
      send_frame(int'(nb), ad, dt);
      if (exp_stb) mdl[ad] = dt;
      if (nb != 5'd12) check_commit("R4 bad count", exp_stb, ad);
      else if (ad >= 4'd12) check_commit("R5 bad addr", exp_stb, ad);
      else check_commit("R3 load", exp_stb, ad);
    end

    // R2: serial clock pulses with select high must be ignored
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) ser_clk = 1'b1;
      @(negedge clk) ser_clk = 1'b0;
    end
    check("R2 idle clocks no change", codes, pack_mdl());
    send_frame(12, 4'd7, 8'h5A);
    mdl[7] = 8'h5A;
    check_commit("R2 frame after idle clocks", 1'b1, 4'd7);

    // R6: preset is asynchronous and wins over a coinciding commit
    @(negedge clk) preset = 1'b1;
    #0.5;
    mdl_mid();
    check("R6 preset async", codes, pack_mdl());
    send_frame(12, 4'd4, 8'h99);
    check_commit("R6 commit under preset", 1'b0, 4'd0);
    @(negedge clk) preset = 1'b0;
    @(negedge clk);
    check("R6 held after release", codes, pack_mdl());
    send_frame(12, 4'd1, 8'h42);
    mdl[1] = 8'h42;
    check_commit("R6 load after preset", 1'b1, 4'd1);

    // R7: shutdown flag, codes retained, loads accepted
    @(negedge clk) shdn = 1'b1;
    @(negedge clk);
    check("R7 sleep set", sleep, 1'b1);
    check("R7 codes kept", codes, pack_mdl());
    send_frame(12, 4'd9, 8'h33);
    mdl[9] = 8'h33;
    check_commit("R7 load in shutdown", 1'b1, 4'd9);
    @(negedge clk) shdn = 1'b0;
    @(negedge clk);
    check("R7 sleep clear", sleep, 1'b0);
    check("R7 codes kept after wake", codes, pack_mdl());

    // R1: reset mid-run returns everything to midscale at once
    @(negedge clk) rst_n = 1'b0;
    #0.5;
    mdl_mid();
    check("R1 async reset codes", codes, pack_mdl());
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    send_frame(12, 4'd11, 8'h0F);
    mdl[11] = 8'h0F;
    check_commit("R3 load after reset", 1'b1, 4'd11);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule